// File: doc/BRIEF.md
# Nibble-Mode Reverse Byte Receiver

This block receives a stream of bytes from a parallel-port peripheral after the link has already been negotiated into the reverse nibble protocol. Each byte arrives as two 4-bit halves on four status lines. The host side asks for each half by lowering its feed line, and the peripheral answers by pulling its acknowledge line low. The receiver rebuilds each byte, hands it out through a one-entry valid/ready register, and at the end of the transfer reports how many bytes arrived and whether the transfer stopped on a timeout or on an I/O fault.

A transfer starts with a one-cycle `start_i` pulse that carries the byte count. The state machine has seven states. `IDLE` waits for start and moves to `SLOT`. `SLOT` moves to `DONE` once the count is reached, or to `REQ_LO` once the output register is free. `REQ_LO` lowers feed and waits for acknowledge low within the long window, then samples the low half and moves to `ACK_LO`; on expiry it moves to `DONE`. `ACK_LO` raises feed and waits for acknowledge high within the short window, moving to `REQ_HI`, or to `DONE` on expiry. `REQ_HI` lowers feed and waits for acknowledge low within the short window. When it sees acknowledge low, or when the window expires, it samples the high half, loads the byte and moves to `ACK_HI`. `ACK_HI` waits for acknowledge high and returns to `SLOT`, or moves to `DONE` on expiry. `DONE` lasts one cycle and returns to `IDLE`.

All five status inputs pass through a two-flop synchroniser before any decision or sample. Wait windows are counted in clock cycles from the cycle the state is entered.

Top module: `nibble_rx`

## Requirements
- R1: After reset, `n_autofd_o` is 1, and `rx_valid_o`, `xfer_done_o`, `err_timeout_o` and `err_io_o` are all 0.
- R2: `start_i` is accepted only in `IDLE`, where `req_len_i` is latched. A `start_i` pulse during a transfer has no effect on the count reported at its end.
- R3: A half-byte is built from the synchronised status lines as bit0 = fault line, bit1 = select line, bit2 = paper-error line, bit3 = busy line. The first half fills byte bits 3:0 and the second half fills bits 7:4.
- R4: `n_autofd_o` is 0 only while a half is being requested. In the cycle after the synchronised acknowledge is seen low during a request, `n_autofd_o` returns to 1. No new request starts before acknowledge is seen high again.
- R5: The wait for the first half of each byte lasts LONG_LIMIT cycles from entry into `REQ_LO`, and a response seen in the last cycle of the window is accepted. Because of the two-flop synchroniser, a peripheral that answers d cycles after it sees feed low is accepted exactly when d + 4 <= LONG_LIMIT. On expiry the transfer ends with `err_timeout_o` = 1, and the count is the number of bytes delivered so far.
- R6: If acknowledge does not return high within SHORT_LIMIT cycles after the first half, the transfer ends with `err_timeout_o` = 1.
- R7: The wait for the second half lasts SHORT_LIMIT cycles. Its expiry is not an error: the status lines are sampled as they stand, and the byte is delivered and counted.
- R8: If acknowledge does not return high within SHORT_LIMIT cycles after the second half, the transfer ends with `err_io_o` = 1. The byte just built is still delivered and counted.
- R9: A byte on `rx_data_o` is held stable with `rx_valid_o` = 1 until a cycle where `rx_ready_i` = 1. No new byte is requested while the register is full, and no byte is lost or reordered.
- R10: `xfer_done_o` is a one-cycle pulse, with `xfer_count_o` equal to the number of bytes delivered. On success the count equals the requested length and both error flags are 0. A length of 0 ends at once with a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted in IDLE only |
| req_len_i | input | CNT_W | Number of bytes to receive |
| st_n_fault_i | input | 1 | Status line carrying half bit 0 |
| st_select_i | input | 1 | Status line carrying half bit 1 |
| st_perror_i | input | 1 | Status line carrying half bit 2 |
| st_busy_i | input | 1 | Status line carrying half bit 3 |
| st_n_ack_i | input | 1 | Peripheral acknowledge, active low |
| n_autofd_o | output | 1 | Host feed line, low requests a half-byte |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Byte register holds a byte |
| rx_ready_i | input | 1 | Consumer takes the byte |
| xfer_done_o | output | 1 | One-cycle end-of-transfer pulse |
| xfer_count_o | output | CNT_W | Bytes delivered in the last transfer |
| err_timeout_o | output | 1 | Last transfer ended on a first-half timeout |
| err_io_o | output | 1 | Last transfer ended on a final acknowledge timeout |

## Verification
Two events can land in the same cycle: the synchronised acknowledge arriving in the last cycle of a wait window, and the expiry of that window. The bench provokes this by sweeping the peripheral's first-half response delay across the window edge, with single-byte transfers. It expects delivery when d + 4 <= LONG_LIMIT and a timeout with a count of 0 otherwise. A second pair is the final-acknowledge expiry with a byte still pending. There the bench checks that the reported count includes that byte and that the byte reaches the consumer.

// File: rtl/nibble_rx_pkg.sv
package nibble_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SLOT   = 3'd1,
        ST_REQ_LO = 3'd2,
        ST_ACK_LO = 3'd3,
        ST_REQ_HI = 3'd4,
        ST_ACK_HI = 3'd5,
        ST_DONE   = 3'd6
    } rx_state_t;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;
    localparam int STAT_W = NIB_W + 1;

endpackage

// File: rtl/nibble_rx_sync.sv
module nibble_rx_sync #(
    parameter int W = 5,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/nibble_rx_timer.sv
module nibble_rx_timer #(
    parameter int MAX_LIMIT = 2000,
    localparam int W = $clog2(MAX_LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (clr)        cnt <= '0;
        else if (cnt != '1)  cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == limit - 1'b1);
endmodule

// File: rtl/nibble_rx_outreg.sv
module nibble_rx_outreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         ready,
    output logic [W-1:0] dout,
    output logic         valid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout  <= '0;
            valid <= 1'b0;
        end else if (load) begin
            dout  <= din;
            valid <= 1'b1;
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/nibble_rx.sv
module nibble_rx
    import nibble_rx_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int LONG_LIMIT  = 2000,
    parameter int SHORT_LIMIT = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] req_len_i,
    input  logic             st_n_fault_i,
    input  logic             st_select_i,
    input  logic             st_perror_i,
    input  logic             st_busy_i,
    input  logic             st_n_ack_i,
    output logic             n_autofd_o,
    output logic [7:0]       rx_data_o,
    output logic             rx_valid_o,
    input  logic             rx_ready_i,
    output logic             xfer_done_o,
    output logic [CNT_W-1:0] xfer_count_o,
    output logic             err_timeout_o,
    output logic             err_io_o
);
    localparam int TMR_W = $clog2(LONG_LIMIT + 1);
    localparam logic [STAT_W-1:0] STAT_IDLE = STAT_W'(1);

    rx_state_t state_q, state_d;

    logic [STAT_W-1:0] stat_raw, stat_s;
    logic              ack_n_s;
    logic [NIB_W-1:0]  nib_now, lo_q;
    logic [CNT_W-1:0]  req_q, rcvd_q;
    logic              err_to_q, err_io_q;
    logic [TMR_W-1:0]  tmr_limit;
    logic              tmr_clr, tmr_exp;
    logic              out_load;

    // status order: {busy, perror, select, fault, ack}
    assign stat_raw = {st_busy_i, st_perror_i, st_select_i, st_n_fault_i, st_n_ack_i};

    nibble_rx_sync #(.W(STAT_W), .STAGES(SYNC_STAGES), .RST_VAL(STAT_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(stat_raw), .q(stat_s)
    );

    assign ack_n_s = stat_s[0];
    assign nib_now = stat_s[STAT_W-1:1];

    assign tmr_limit = (state_q == ST_REQ_LO) ? TMR_W'(LONG_LIMIT) : TMR_W'(SHORT_LIMIT);
    assign tmr_clr   = (state_d != state_q);

    nibble_rx_timer #(.MAX_LIMIT(LONG_LIMIT)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .limit(tmr_limit), .expired(tmr_exp)
    );

    assign out_load = (state_q == ST_REQ_HI) && (!ack_n_s || tmr_exp);

    nibble_rx_outreg #(.W(BYTE_W)) u_out (
        .clk(clk), .rst_n(rst_n), .load(out_load), .din({nib_now, lo_q}),
        .ready(rx_ready_i), .dout(rx_data_o), .valid(rx_valid_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_SLOT;
            ST_SLOT: begin
                if (rcvd_q == req_q)  state_d = ST_DONE;
                else if (!rx_valid_o) state_d = ST_REQ_LO;
            end
            ST_REQ_LO: begin
                if (!ack_n_s)     state_d = ST_ACK_LO;
                else if (tmr_exp) state_d = ST_DONE;
            end
            ST_ACK_LO: begin
                if (ack_n_s)      state_d = ST_REQ_HI;
                else if (tmr_exp) state_d = ST_DONE;
            end
            ST_REQ_HI: if (!ack_n_s || tmr_exp) state_d = ST_ACK_HI;
            ST_ACK_HI: begin
                if (ack_n_s)      state_d = ST_SLOT;
                else if (tmr_exp) state_d = ST_DONE;
            end
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        n_autofd_o  = !((state_q == ST_REQ_LO) || (state_q == ST_REQ_HI));
        xfer_done_o = (state_q == ST_DONE);
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q    <= '0;
            rcvd_q   <= '0;
            lo_q     <= '0;
            err_to_q <= 1'b0;
            err_io_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    req_q    <= req_len_i;
                    rcvd_q   <= '0;
                    err_to_q <= 1'b0;
                    err_io_q <= 1'b0;
                end
                ST_REQ_LO: begin
                    if (!ack_n_s)     lo_q     <= nib_now;
                    else if (tmr_exp) err_to_q <= 1'b1;
                end
                ST_ACK_LO: if (!ack_n_s && tmr_exp) err_to_q <= 1'b1;
                ST_REQ_HI: if (out_load) rcvd_q <= rcvd_q + 1'b1;
                ST_ACK_HI: if (!ack_n_s && tmr_exp) err_io_q <= 1'b1;
                default: ;
            endcase
        end
    end

    assign xfer_count_o  = rcvd_q;
    assign err_timeout_o = err_to_q;
    assign err_io_o      = err_io_q;

endmodule

// File: rtl/nibble_rx_chk.sv
module nibble_rx_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             n_autofd,
    input logic             ack_n_s,
    input logic             out_load,
    input logic             rx_valid,
    input logic             rx_ready,
    input logic [7:0]       rx_data,
    input logic             xfer_done,
    input logic [CNT_W-1:0] xfer_count,
    input logic [CNT_W-1:0] req_q,
    input logic             err_to,
    input logic             err_io
);
    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        out_load |-> !rx_valid); // R9
    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R9
    AST_FEED_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!n_autofd && !ack_n_s) |=> n_autofd); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done); // R10
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (xfer_count <= req_q)); // R10
    AST_OK_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !err_to && !err_io) |-> (xfer_count == req_q)); // R10
    AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> !(err_to && err_io)); // R6
endmodule

bind nibble_rx nibble_rx_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .n_autofd(n_autofd_o), .ack_n_s(ack_n_s),
    .out_load(out_load), .rx_valid(rx_valid_o), .rx_ready(rx_ready_i),
    .rx_data(rx_data_o), .xfer_done(xfer_done_o), .xfer_count(xfer_count_o),
    .req_q(req_q), .err_to(err_timeout_o), .err_io(err_io_o)
);

// File: tb/test_nibble_rx.sv
`timescale 1ns/1ps
module test_nibble_rx;
    localparam int LONG  = 40;
    localparam int SHORT = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] req_len = '0;
    logic       st_fault = 1'b0, st_sel = 1'b0, st_pe = 1'b0, st_busy = 1'b0, st_ack = 1'b1;
    logic       n_autofd;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_ready = 1'b0;
    logic       xfer_done;
    logic [7:0] xfer_count;
    logic       err_to, err_io;

    always #2.5 clk = ~clk;

    nibble_rx #(.CNT_W(8), .LONG_LIMIT(LONG), .SHORT_LIMIT(SHORT)) i_nibble_rx (
        .clk(clk), .rst_n(rst_n), .start_i(start), .req_len_i(req_len),
        .st_n_fault_i(st_fault), .st_select_i(st_sel), .st_perror_i(st_pe),
        .st_busy_i(st_busy), .st_n_ack_i(st_ack), .n_autofd_o(n_autofd),
        .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
        .xfer_done_o(xfer_done), .xfer_count_o(xfer_count),
        .err_timeout_o(err_to), .err_io_o(err_io)
    );

    int n_chk = 0, n_err = 0;

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // peripheral model
    logic [7:0] src [256];
    int  dly = 1, dly_first = 1, stall = 0, stall_byte = 0;
    bit  p_run = 0;
    int  ph = 0, dcnt = 0, half = 0, bidx = 0;

    always @(negedge clk) begin
        if (!p_run) begin
            ph = 0; half = 0; bidx = 0; st_ack = 1'b1;
        end else begin
            bit hit;
            logic [3:0] nib;
            hit = (bidx == stall_byte) &&
                  (stall == ((ph == 1) ? (half ? 3 : 1) : (ph == 3) ? (half ? 4 : 2) : -1));
            case (ph)
                0: if (!n_autofd) begin dcnt = half ? dly : dly_first; ph = 1; end
                1: if (!hit) begin
                       if (dcnt == 0) begin
                           nib = half ? src[bidx][7:4] : src[bidx][3:0];
                           st_fault = nib[0]; st_sel = nib[1]; st_pe = nib[2]; st_busy = nib[3];
                           st_ack = 1'b0; ph = 2;
                       end else dcnt--;
                   end
                2: if (n_autofd) begin dcnt = dly; ph = 3; end
                3: if (!hit) begin
                       if (dcnt == 0) begin
                           st_ack = 1'b1;
                           if (half == 1) bidx++;
                           half ^= 1; ph = 0;
                       end else dcnt--;
                   end
                default: ph = 0;
            endcase
        end
    end

    // consumer, done capture and watchdog
    int  ready_mode = 0, cyc = 0, ngot = 0, d_count = 0;
    logic [7:0] got [256];
    bit  done_seen = 0, d_to = 0, d_io = 0;

    always @(negedge clk) begin
        cyc++;
        rx_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 7) < 3);
        if (rx_valid && rx_ready && ngot < 256) begin
            got[ngot] = rx_data;
            ngot++;
        end
        if (xfer_done) begin
            done_seen = 1; d_count = xfer_count; d_to = err_to; d_io = err_io;
        end
        if (cyc > 150000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    task automatic run_xfer(int len, bit poke);
        ngot = 0; done_seen = 0; p_run = 1;
        @(negedge clk); start = 1'b1; req_len = 8'(len);
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 20000 && !done_seen; i++) begin
            @(negedge clk);
            if (poke && i == 50) begin start = 1'b1; req_len = 8'd3; end
            else start = 1'b0;
        end
        check("R10 done pulse seen", int'(done_seen), 1);
        repeat (30) @(negedge clk);
        p_run = 0;
        repeat (6) @(negedge clk);
    endtask

    task automatic expect_end(string tag, int cnt, int to, int io);
        check({tag, " count"}, d_count, cnt);
        check({tag, " timeout flag"}, int'(d_to), to);
        check({tag, " io flag"}, int'(d_io), io);
        check({tag, " bytes consumed"}, ngot, cnt);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 feed idle high", int'(n_autofd), 1);
        check("R1 valid low", int'(rx_valid), 0);
        check("R1 done low", int'(xfer_done), 0);
        check("R1 timeout low", int'(err_to), 0);
        check("R1 io low", int'(err_io), 0);

        // zero length
        run_xfer(0, 0);
        expect_end("R10 zero length", 0, 0, 0);

        // sweep A: values 0..127, fast peripheral, ready always
        for (int i = 0; i < 128; i++) src[i] = 8'(i);
        dly = 0; dly_first = 0; stall = 0; ready_mode = 0;
        run_xfer(128, 0);
        expect_end("R10 sweep A", 128, 0, 0);
        for (int i = 0; i < 128; i++) check("R3 sweep A byte", int'(got[i]), i);

        // sweep B: values 128..255, slower peripheral, back-pressure
        for (int i = 0; i < 128; i++) src[i] = 8'(128 + i);
        dly = 3; dly_first = 5; ready_mode = 1;
        run_xfer(128, 0);
        expect_end("R9 sweep B", 128, 0, 0);
        for (int i = 0; i < 128; i++) check("R9 R3 sweep B byte", int'(got[i]), 128 + i);
        ready_mode = 0;

        // start during active transfer ignored
        for (int i = 0; i < 10; i++) src[i] = 8'(i * 3 + 1);
        dly = 1; dly_first = 1;
        run_xfer(10, 1);
        expect_end("R2 start ignored", 10, 0, 0);
        for (int i = 0; i < 10; i++) check("R2 byte", int'(got[i]), i * 3 + 1);

        // first-half window edge
        for (int d = LONG - 6; d <= LONG - 2; d++) begin
            src[0] = 8'h5A; dly = 1; dly_first = d;
            run_xfer(1, 0);
            if (d + 4 <= LONG) begin
                expect_end("R5 window inside", 1, 0, 0);
                check("R5 window byte", int'(got[0]), 8'h5A);
            end else begin
                expect_end("R5 window expired", 0, 1, 0);
            end
        end

        // stalls at byte 2 of 5
        for (int i = 0; i < 5; i++) src[i] = 8'hC3 ^ 8'(i * 29);
        dly = 1; dly_first = 1; stall_byte = 2;

        stall = 1; run_xfer(5, 0);
        expect_end("R5 first half stall", 2, 1, 0);

        stall = 2; run_xfer(5, 0);
        expect_end("R6 first ack stall", 2, 1, 0);

        stall = 3; run_xfer(5, 0);
        expect_end("R7 second half stall", 3, 1, 0);
        check("R7 byte from held lines", int'(got[2]), int'({src[2][3:0], src[2][3:0]}));
        check("R7 earlier byte", int'(got[1]), int'(src[1]));

        stall = 4; run_xfer(5, 0);
        expect_end("R8 final ack stall", 3, 0, 1);
        check("R8 last byte delivered", int'(got[2]), int'(src[2]));
        stall = 0;

        check("R4 feed idle after runs", int'(n_autofd), 1);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule